// File: doc/BRIEF.md
# Aligned Byte-Lane Load/Store Unit

This block sits between the load/store stage of a processor and a data memory that is one 64-bit doubleword wide. Each request carries a byte address and one of four access sizes: byte, half word, word or doubleword. It also carries a load/store flag, store data, a signed/unsigned flag for loads and an endianness select. The block checks that the address is a whole multiple of the access size. If it is, the block drives a single-cycle memory access. If it is not, no access is made and a sticky fault flag is raised for system software.

For stores, the value is moved onto the byte lanes of the doubleword that the addressed bytes occupy, and byte enables mark exactly those lanes. For loads, the memory returns the whole doubleword one cycle later. The block takes the addressed lanes from that doubleword and widens the result to 64 bits, with sign or zero fill.

The endianness select changes how byte addresses map to lanes. With little-endian numbering, byte offset `o` inside the doubleword is lane `o`. With big-endian numbering, it is lane `7-o`. Lane `i` is data bits `8i+7:8i`.

Top module: `lsu_lane_unit`

## Requirements
- R1: A byte access (size code 0) is never reported as misaligned, whatever its address.
- R2: A half-word (code 1), word (code 2) or doubleword (code 3) access is misaligned when address bit 0, bits 1:0 or bits 2:0 respectively are not all zero.
- R3: A misaligned request drives `mem_en` low and `mem_be` to zero. It also produces no `ld_valid` in the next cycle.
- R4: The clock edge of a misaligned request sets `trap_flag` and loads `trap_addr` with its address. Both then hold until `trap_clr` is high at an edge. A later fault while the flag is set does not replace the stored address.
- R5: If `trap_clr` and a new misaligned request arrive in the same cycle, the new fault wins: the flag stays set and `trap_addr` takes the new address.
- R6: In little-endian mode (`req_big` = 0), value byte `k` of an aligned access at doubleword offset `o` goes to lane `o+k`. Lanes not covered carry zero on `mem_wdata`.
- R7: In big-endian mode (`req_big` = 1), value byte `k` of an `s`-byte access at offset `o` goes to lane `8-o-s+k`. The most significant value byte therefore sits at the lowest address.
- R8: For an aligned access, `mem_be` has exactly one bit set for each byte of the access, on the lanes given by R6/R7. `mem_en` is high, `mem_we` follows `req_store`, and `mem_word_addr` is `req_addr >> 3`.
- R9: An aligned load raises `ld_valid` in the next cycle. In that cycle `ld_data` holds the addressed bytes, taken from `mem_rdata` with the same lane mapping as the store.
- R10: A load narrower than 64 bits is sign-extended when `req_signed` = 1 and zero-extended when it is 0.
- R11: After reset, `trap_flag`, `trap_addr`, `ld_valid` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_signed | input | 1 | Load sign-extension select |
| req_big | input | 1 | 1 = big-endian lane numbering |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store value, right-justified |
| trap_clr | input | 1 | Clears the pending fault |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_word_addr | output | ADDR_W-3 | Doubleword index |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-steered store data |
| mem_rdata | input | 64 | Doubleword returned one cycle after a read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |
| trap_flag | output | 1 | Sticky misalignment fault |
| trap_addr | output | ADDR_W | Address of the captured fault |

## Verification
Fault clearing and fault capture can meet in one cycle. The bench provokes this in two ways. A directed step raises `trap_clr` together with a misaligned request. Random steps pulse `trap_clr` often enough to land on faulting requests. After each edge, the bench compares the flag and the captured address with a shadow model: a new fault must win over a clear, and a fault that arrives while the flag is set must leave the stored address untouched. Loads that read back lanes written under the other endianness are also judged against a lane-level shadow of memory.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int LANES = 8;
  localparam int OFF_W = 3;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} acc_size_e;

  function automatic logic [3:0] size_bytes(acc_size_e sz);
    return 4'd1 << sz;
  endfunction

  function automatic logic is_misaligned(acc_size_e sz, logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE:  return 1'b0;
      SZ_HALF:  return off[0];
      SZ_WORD:  return |off[1:0];
      default:  return |off;
    endcase
  endfunction

  // first lane occupied by the value's least significant byte
  function automatic logic [OFF_W-1:0] lane_base(acc_size_e sz, logic [OFF_W-1:0] off,
                                                 logic big);
    logic [3:0] t;
    t = 4'd8 - {1'b0, off} - size_bytes(sz);
    return big ? t[OFF_W-1:0] : off;
  endfunction

  function automatic logic [63:0] size_mask(acc_size_e sz);
    case (sz)
      SZ_BYTE:  return 64'h0000_0000_0000_00FF;
      SZ_HALF:  return 64'h0000_0000_0000_FFFF;
      SZ_WORD:  return 64'h0000_0000_FFFF_FFFF;
      default:  return '1;
    endcase
  endfunction

  function automatic logic [63:0] extend(acc_size_e sz, logic sgn, logic [63:0] v);
    case (sz)
      SZ_BYTE:  return {{56{sgn & v[7]}},  v[7:0]};
      SZ_HALF:  return {{48{sgn & v[15]}}, v[15:0]};
      SZ_WORD:  return {{32{sgn & v[31]}}, v[31:0]};
      default:  return v;
    endcase
  endfunction
endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk
  import lane_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             mis_o
);
  assign mis_o = is_misaligned(size_i, off_i);

  AST_BYTE_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == SZ_BYTE) |-> !mis_o);  // R1
  AST_DWORD_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == SZ_DWORD && off_i != '0) |-> mis_o);  // R2
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
  import lane_pkg::*;
(
  input  logic             en_i,
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] base_i,
  input  logic [63:0]      wdata_i,
  output logic [LANES-1:0] be_o,
  output logic [63:0]      wdata_o
);
  logic [3:0] top_w;
  assign top_w = {1'b0, base_i} + size_bytes(size_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[i] = en_i && (4'(i) >= {1'b0, base_i}) && (4'(i) < top_w);
  end

  assign wdata_o = en_i ? ((wdata_i & size_mask(size_i)) << {base_i, 3'b000}) : '0;
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] base_i,
  input  logic             signed_i,
  input  logic [63:0]      rdata_i,
  output logic [63:0]      data_o
);
  logic [63:0] shifted;
  assign shifted = rdata_i >> {base_i, 3'b000};
  assign data_o  = extend(size_i, signed_i, shifted);
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_big,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic              trap_clr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_word_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              ld_valid,
  output logic [63:0]       ld_data,
  output logic              trap_flag,
  output logic [ADDR_W-1:0] trap_addr
);
  acc_size_e        sz;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] base;
  logic             mis;
  logic             fault_evt;
  logic             acc_ok;
  logic [63:0]      ext_data;

  acc_size_e        ld_size_q;
  logic [OFF_W-1:0] ld_base_q;
  logic             ld_signed_q;
  logic             ld_valid_q;
  logic             trap_q;
  logic [ADDR_W-1:0] taddr_q;

  assign sz        = acc_size_e'(req_size);
  assign off       = req_addr[OFF_W-1:0];
  assign base      = lane_base(sz, off, req_big);
  assign fault_evt = req_valid && mis;
  assign acc_ok    = req_valid && !mis;

  lane_align_chk i_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .size_i (sz),
    .off_i  (off),
    .mis_o  (mis)
  );

  lane_store_steer i_steer (
    .en_i    (acc_ok),
    .size_i  (sz),
    .base_i  (base),
    .wdata_i (req_wdata),
    .be_o    (mem_be),
    .wdata_o (mem_wdata)
  );

  lane_load_extract i_extract (
    .size_i   (ld_size_q),
    .base_i   (ld_base_q),
    .signed_i (ld_signed_q),
    .rdata_i  (mem_rdata),
    .data_o   (ext_data)
  );

  assign mem_en        = acc_ok;
  assign mem_we        = acc_ok && req_store;
  assign mem_word_addr = req_addr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_q  <= 1'b0;
      ld_size_q   <= SZ_BYTE;
      ld_base_q   <= '0;
      ld_signed_q <= 1'b0;
    end else begin
      ld_valid_q <= acc_ok && !req_store;
      if (acc_ok && !req_store) begin
        ld_size_q   <= sz;
        ld_base_q   <= base;
        ld_signed_q <= req_signed;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      taddr_q <= '0;
    end else if (fault_evt && (!trap_q || trap_clr)) begin
      trap_q  <= 1'b1;
      taddr_q <= req_addr;
    end else if (trap_clr) begin
      trap_q  <= 1'b0;
    end
  end

  assign ld_valid  = ld_valid_q;
  assign ld_data   = ld_valid_q ? ext_data : '0;
  assign trap_flag = trap_q;
  assign trap_addr = taddr_q;

  AST_NO_LANES_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> (mem_be == '0 && mem_wdata == '0));  // R3
  AST_NO_LOAD_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !ld_valid);  // R3
  AST_TRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && !trap_flag) |=> (trap_flag && trap_addr == $past(req_addr)));  // R4
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_flag && !trap_clr) |=> (trap_flag && $stable(trap_addr)));  // R4
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && trap_clr) |=> (trap_flag && trap_addr == $past(req_addr)));  // R5
  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == int'(size_bytes(sz))));  // R8
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !mis) |=> ld_valid);  // R9
endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_big = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          trap_clr = 1'b0;
  logic          mem_en, mem_we, ld_valid, trap_flag;
  logic [AW-4:0] mem_word_addr;
  logic [7:0]    mem_be;
  logic [63:0]   mem_wdata, ld_data;
  logic [63:0]   mem_rdata = '0;
  logic [AW-1:0] trap_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] mem_model [16];
  logic [7:0]  shadow [16][8];
  logic          exp_trap = 1'b0;
  logic [AW-1:0] exp_taddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit #(.ADDR_W(AW)) i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_big(req_big),
    .req_addr(req_addr), .req_wdata(req_wdata), .trap_clr(trap_clr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_word_addr(mem_word_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .trap_flag(trap_flag),
    .trap_addr(trap_addr)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int i = 0; i < 8; i++)
          if (mem_be[i]) mem_model[mem_word_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else begin
        mem_rdata <= mem_model[mem_word_addr[3:0]];
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lane holding value byte i, walked address by address
  function automatic int lane_of(input logic big, input int off, input int s, input int i);
    int a;
    a = off + (big ? (s - 1 - i) : i);
    return big ? 7 - a : a;
  endfunction

  task automatic access(input logic st, input int szc, input logic sgn, input logic big,
                        input logic [AW-1:0] addr, input logic [63:0] val, input logic clr);
    int s, off, w;
    logic mis;
    logic [7:0]  ebe;
    logic [63:0] ewd, eld;
    s = 1 << szc;
    off = int'(addr[2:0]);
    w = int'(addr[6:3]);
    mis = (off % s) != 0;
    ebe = '0; ewd = '0; eld = '0;
    if (!mis) begin
      for (int i = 0; i < s; i++) begin
        ebe[lane_of(big, off, s, i)] = 1'b1;
        ewd[8*lane_of(big, off, s, i) +: 8] = val[8*i +: 8];
        eld[8*i +: 8] = shadow[w][lane_of(big, off, s, i)];
      end
      if (s < 8 && sgn && eld[8*s-1])
        for (int b = 8*s; b < 64; b++) eld[b] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = 2'(szc); req_signed = sgn;
    req_big = big; req_addr = addr; req_wdata = val; trap_clr = clr;
    #1;
    if (mis) begin
      chk(!mem_en && mem_be == 8'h00, "R3 no access on fault", {56'd0, mem_be}, 64'd0);
    end else begin
      chk(mem_en && mem_we == st && mem_word_addr == addr[AW-1:3],
          "R8 enable/we/word address", {32'd0, mem_word_addr}, {35'd0, addr[AW-1:3]});
      chk(mem_be == ebe, "R8 byte enables", {56'd0, mem_be}, {56'd0, ebe});
      if (st) chk(mem_wdata == ewd, big ? "R7 big-endian store lanes" : "R6 little-endian store lanes",
                  mem_wdata, ewd);
      if (szc == 0) chk(1'b1, "R1 byte aligned", 64'd0, 64'd0);
    end
    if (mis) begin
      if (!exp_trap || clr) begin exp_trap = 1'b1; exp_taddr = addr; end
    end else if (clr) exp_trap = 1'b0;
    if (!mis && st)
      for (int i = 0; i < s; i++) shadow[w][lane_of(big, off, s, i)] = val[8*i +: 8];
    @(negedge clk);
    req_valid = 1'b0; trap_clr = 1'b0;
    #1;
    chk(trap_flag == exp_trap && trap_addr == exp_taddr,
        mis ? (clr ? "R5 fault beats clear" : "R2 R4 trap capture/hold") : "R4 trap held",
        {31'd0, trap_flag, trap_addr}, {31'd0, exp_trap, exp_taddr});
    if (!mis && !st) begin
      chk(ld_valid == 1'b1 && ld_data == eld,
          (s < 8) ? "R9 R10 load data and extension" : "R9 load data", ld_data, eld);
    end else begin
      chk(ld_valid == 1'b0, mis ? "R3 no load on fault" : "R9 no load after store",
          {63'd0, ld_valid}, 64'd0);
    end
  endtask

  task automatic clear_only();
    @(negedge clk);
    trap_clr = 1'b1;
    @(negedge clk);
    trap_clr = 1'b0;
    exp_trap = 1'b0;
    #1;
    chk(trap_flag == 1'b0, "R4 clear", {63'd0, trap_flag}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin
      mem_model[i] = '0;
      for (int j = 0; j < 8; j++) shadow[i][j] = 8'h00;
    end
    #(CLK_PERIOD * 3);
    #1;
    chk(trap_flag == 1'b0 && trap_addr == '0 && ld_valid == 1'b0 && ld_data == '0,
        "R11 reset state", {31'd0, trap_flag, trap_addr}, 64'd0);
    rst_n = 1'b1;

    // directed corners
    access(1'b1, 3, 1'b0, 1'b0, 32'h0000_0000, 64'h8877_6655_4433_2211, 1'b0);
    access(1'b0, 0, 1'b1, 1'b0, 32'h0000_0007, 64'd0, 1'b0);            // R10 0x88 signed
    access(1'b0, 0, 1'b0, 1'b0, 32'h0000_0007, 64'd0, 1'b0);            // R10 zero fill
    access(1'b0, 1, 1'b0, 1'b1, 32'h0000_0000, 64'd0, 1'b0);            // R7 read big
    access(1'b1, 2, 1'b0, 1'b1, 32'h0000_000C, 64'h0000_0000_A1B2_C3D4, 1'b0);
    access(1'b0, 2, 1'b1, 1'b1, 32'h0000_000C, 64'd0, 1'b0);
    access(1'b0, 2, 1'b1, 1'b0, 32'h0000_000C, 64'd0, 1'b0);
    access(1'b1, 0, 1'b0, 1'b1, 32'h0000_0017, 64'h0000_0000_0000_00EE, 1'b0);
    access(1'b0, 1, 1'b0, 1'b0, 32'h0000_0031, 64'd0, 1'b0);            // R2 half odd
    access(1'b1, 3, 1'b0, 1'b0, 32'h0000_0044, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); // R4 keeps first
    access(1'b0, 2, 1'b0, 1'b0, 32'h0000_0046, 64'd0, 1'b1);            // R5 clear + fault
    clear_only();

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      access(r[0], int'(r[2:1]), r[3], r[4], {25'd0, r[11:5]},
             {$urandom, $urandom}, (r[15:12] == 4'd0));
      if (r[19:16] == 4'd0 && exp_trap) clear_only();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule